// File: doc/BRIEF.md
# Pipeline Exception Annul Controller

This block gives a five-stage in-order pipeline (fetch, decode/register read, execute, memory, write-back) precise exceptions. Each cycle the four stages that can fault report a flag: a fetch memory fault, an illegal opcode at decode, a zero divisor at execute, and a bad data address at the memory stage. An external interrupt request is also sampled. The controller picks the oldest faulting instruction. It rewrites that instruction into a capture branch whose only effect is to save its PC+4. It turns every younger instruction into a NOP and lets every older instruction run to completion.

The block drives a two-bit instruction-source select for each stage register input. In the cycle of detection it also raises a redirect with the handler address, so the fetch stage works on the first handler instruction in the next cycle. The controller keeps its own copy of the instruction words as they move through the stage registers. It also tags each slot as live, annulled or capture. A slot that has already been rewritten cannot fault again, so a fault from an older instruction that appears later overrides a younger one already being handled.

Top module: `exc_annul_ctrl`

## Requirements
- R1: While reset is held, and right after it, all four stage valid outputs are 0, every select is 2'b00 and redirect is 0.
- R2: With no qualified fault, every select is 2'b00 (pass). A fetched word reaches the decode, execute, memory and write-back word outputs 1, 2, 3 and 4 cycles later, and its valid bit moves with it.
- R3: When stage s wins, its select is 2'b10 (capture branch), every younger stage's select is 2'b01 (NOP), every older stage's select is 2'b00, and redirect is 1 in that same cycle.
- R4: In the cycle after a select, the next stage's word output holds CAPTURE_WORD where the select was 2'b10 and NOP_WORD where it was 2'b01.
- R5: When several stages fault in the same cycle, the stage furthest down wins. The order from highest priority is memory, execute, decode, fetch.
- R6: handler_pc is VEC_DADDR, VEC_DIVZERO or VEC_ILLEGAL when the memory, execute or decode stage wins, and VEC_IFETCH when the fetch stage wins through a fetch fault. It is 0 when redirect is 0.
- R7: A fault flag from a stage that holds no valid instruction is ignored. A fetch fault or interrupt with fetch_valid low is ignored too.
- R8: A stage that holds an annulled NOP or a capture branch ignores its fault flag.
- R9: An interrupt request with fetch_valid high acts as a fetch-stage exception with vector VEC_IRQ. When a fetch fault occurs in the same cycle, VEC_IFETCH is used instead.
- R10: A fault from an older instruction in the cycle after a younger one was captured takes over. It captures the older instruction, annuls everything younger (including the earlier capture branch) and redirects to its own vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_word | input | W | Instruction word being fetched this cycle |
| fetch_valid | input | 1 | Fetch stage holds a real instruction |
| fault_ifetch | input | 1 | Fetch memory fault |
| fault_illegal | input | 1 | Illegal opcode at decode |
| fault_divzero | input | 1 | Zero divisor at execute |
| fault_daddr | input | 1 | Illegal data address at memory stage |
| irq_req | input | 1 | External interrupt request |
| sel_if | output | 2 | Source select for the fetch stage's instruction |
| sel_rf | output | 2 | Source select for the decode stage's instruction |
| sel_alu | output | 2 | Source select for the execute stage's instruction |
| sel_mem | output | 2 | Source select for the memory stage's instruction |
| redirect | output | 1 | Load the PC with handler_pc |
| handler_pc | output | AW | Handler address of the winning exception |
| rf_word | output | W | Word in the decode stage register |
| rf_valid | output | 1 | Decode slot valid |
| alu_word | output | W | Word in the execute stage register |
| alu_valid | output | 1 | Execute slot valid |
| mem_word | output | W | Word in the memory stage register |
| mem_valid | output | 1 | Memory slot valid |
| wb_word | output | W | Word in the write-back stage register |
| wb_valid | output | 1 | Write-back slot valid |

## Verification
The bench targets the override case: a decode fault followed by a memory fault from the older load in the next cycle. A controller that kept the first exception would leave the capture branch in place and jump to the illegal-opcode vector. It also floods every stage with faults in one cycle, where a wrong priority encoder would capture a younger instruction. It raises faults on slots that hold NOPs or capture branches, where a missing tag would cause spurious second redirects. It also combines an interrupt with a fetch fault and with an idle fetch, which would expose a wrong vector or an interrupt taken on a bubble.

// File: rtl/exc_ctl_pkg.sv
package exc_ctl_pkg;

    // Number of stages able to fault: fetch, decode, execute, memory.
    localparam int N_FAULT = 4;

    localparam int ST_IF  = 0;
    localparam int ST_RF  = 1;
    localparam int ST_ALU = 2;
    localparam int ST_MEM = 3;

    // Instruction-source select driven to each stage register input.
    typedef enum logic [1:0] {
        SEL_PASS    = 2'b00,
        SEL_NOP     = 2'b01,
        SEL_CAPTURE = 2'b10
    } isel_e;

    // What a stage slot currently holds.
    typedef enum logic [1:0] {
        TAG_LIVE  = 2'b00,
        TAG_ANNUL = 2'b01,
        TAG_CAPT  = 2'b10
    } slot_tag_e;

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_ctl_pkg::*;
#(
    parameter int             N           = N_FAULT,
    parameter int             AW          = 32,
    parameter logic [AW-1:0]  VEC_IFETCH  = 32'h0000_0100,
    parameter logic [AW-1:0]  VEC_ILLEGAL = 32'h0000_0200,
    parameter logic [AW-1:0]  VEC_DIVZERO = 32'h0000_0300,
    parameter logic [AW-1:0]  VEC_DADDR   = 32'h0000_0400,
    parameter logic [AW-1:0]  VEC_IRQ     = 32'h0000_0500
) (
    input  logic [N-1:0]      hit,
    input  logic              fetch_fault,
    output logic [N-1:0][1:0] sel,
    output logic              take,
    output logic [AW-1:0]     vector
);

    localparam int WIN_W = (N > 1) ? $clog2(N) : 1;

    logic [WIN_W-1:0] win;
    logic             found;

    // Priority: the highest index (oldest instruction) wins.
    always_comb begin
        win   = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (hit[i]) begin
                win   = WIN_W'(i);
                found = 1'b1;
            end
        end
    end

    // Capture at the winner, annul everything younger, pass older stages.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            if (!found)
                sel[i] = SEL_PASS;
            else if (WIN_W'(i) == win)
                sel[i] = SEL_CAPTURE;
            else if (WIN_W'(i) < win)
                sel[i] = SEL_NOP;
            else
                sel[i] = SEL_PASS;
        end
    end

    always_comb begin
        take   = found;
        vector = '0;
        if (found) begin
            unique case (int'(win))
                ST_IF:   vector = fetch_fault ? VEC_IFETCH : VEC_IRQ;
                ST_RF:   vector = VEC_ILLEGAL;
                ST_ALU:  vector = VEC_DIVZERO;
                default: vector = VEC_DADDR;
            endcase
        end
    end

endmodule

// File: rtl/exc_stage_regs.sv
module exc_stage_regs
    import exc_ctl_pkg::*;
#(
    parameter int            N            = N_FAULT,
    parameter int            W            = 32,
    parameter logic [W-1:0]  NOP_WORD     = 32'hA000_0000,
    parameter logic [W-1:0]  CAPTURE_WORD = 32'hB000_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      fetch_word,
    input  logic              fetch_valid,
    input  logic [N-1:0][1:0] sel,
    output logic [N-1:0][W-1:0] slot_word,
    output logic [N-1:0]      slot_valid,
    output logic [N-2:0]      slot_live
);

    // Slot k is the register feeding stage k+1 (decode .. write-back).
    typedef struct packed {
        logic [N-1:0][W-1:0] word;
        logic [N-1:0]        valid;
        slot_tag_e [N-1:0]   tag;
    } slots_t;

    slots_t st_d, st_q;

    logic [W-1:0] src_word;
    logic         src_valid;
    slot_tag_e    src_tag;

    always_comb begin
        st_d      = st_q;
        src_word  = '0;
        src_valid = 1'b0;
        src_tag   = TAG_LIVE;
        for (int k = 0; k < N; k++) begin
            if (k == 0) begin
                src_word  = fetch_word;
                src_valid = fetch_valid;
                src_tag   = TAG_LIVE;
            end else begin
                src_word  = st_q.word[k-1];
                src_valid = st_q.valid[k-1];
                src_tag   = st_q.tag[k-1];
            end
            st_d.valid[k] = src_valid;
            case (isel_e'(sel[k]))
                SEL_NOP: begin
                    st_d.word[k] = NOP_WORD;
                    st_d.tag[k]  = TAG_ANNUL;
                end
                SEL_CAPTURE: begin
                    st_d.word[k] = CAPTURE_WORD;
                    st_d.tag[k]  = TAG_CAPT;
                end
                default: begin
                    st_d.word[k] = src_word;
                    st_d.tag[k]  = src_tag;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign slot_word  = st_q.word;
    assign slot_valid = st_q.valid;

    // Only a valid, untouched instruction may raise a fault.
    for (genvar g = 0; g < N - 1; g++) begin : g_live
        assign slot_live[g] = st_q.valid[g] && (st_q.tag[g] == TAG_LIVE);
    end

endmodule

// File: rtl/exc_annul_ctrl.sv
module exc_annul_ctrl
    import exc_ctl_pkg::*;
#(
    parameter int            W            = 32,
    parameter int            AW           = 32,
    parameter logic [W-1:0]  NOP_WORD     = 32'hA000_0000,
    parameter logic [W-1:0]  CAPTURE_WORD = 32'hB000_0001,
    parameter logic [AW-1:0] VEC_IFETCH   = 32'h0000_0100,
    parameter logic [AW-1:0] VEC_ILLEGAL  = 32'h0000_0200,
    parameter logic [AW-1:0] VEC_DIVZERO  = 32'h0000_0300,
    parameter logic [AW-1:0] VEC_DADDR    = 32'h0000_0400,
    parameter logic [AW-1:0] VEC_IRQ      = 32'h0000_0500
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  fetch_word,
    input  logic          fetch_valid,
    input  logic          fault_ifetch,
    input  logic          fault_illegal,
    input  logic          fault_divzero,
    input  logic          fault_daddr,
    input  logic          irq_req,
    output logic [1:0]    sel_if,
    output logic [1:0]    sel_rf,
    output logic [1:0]    sel_alu,
    output logic [1:0]    sel_mem,
    output logic          redirect,
    output logic [AW-1:0] handler_pc,
    output logic [W-1:0]  rf_word,
    output logic          rf_valid,
    output logic [W-1:0]  alu_word,
    output logic          alu_valid,
    output logic [W-1:0]  mem_word,
    output logic          mem_valid,
    output logic [W-1:0]  wb_word,
    output logic          wb_valid
);

    localparam int NS = N_FAULT;

    logic [NS-1:0]         raw;
    logic [NS-1:0]         hit;
    logic [NS-1:0][1:0]    sel;
    logic [NS-2:0]         live;
    logic [NS-1:0][W-1:0]  word;
    logic [NS-1:0]         valid;

    // The interrupt is folded into the fetch stage's fault.
    assign raw = {fault_daddr, fault_divzero, fault_illegal, fault_ifetch | irq_req};

    for (genvar g = 0; g < NS; g++) begin : g_qual
        if (g == 0) begin : g_fetch
            assign hit[g] = raw[g] && fetch_valid;
        end else begin : g_slot
            assign hit[g] = raw[g] && live[g-1];
        end
    end

    exc_arbiter #(
        .N           (NS),
        .AW          (AW),
        .VEC_IFETCH  (VEC_IFETCH),
        .VEC_ILLEGAL (VEC_ILLEGAL),
        .VEC_DIVZERO (VEC_DIVZERO),
        .VEC_DADDR   (VEC_DADDR),
        .VEC_IRQ     (VEC_IRQ)
    ) u_arb (
        .hit         (hit),
        .fetch_fault (fault_ifetch),
        .sel         (sel),
        .take        (redirect),
        .vector      (handler_pc)
    );

    exc_stage_regs #(
        .N            (NS),
        .W            (W),
        .NOP_WORD     (NOP_WORD),
        .CAPTURE_WORD (CAPTURE_WORD)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_word  (fetch_word),
        .fetch_valid (fetch_valid),
        .sel         (sel),
        .slot_word   (word),
        .slot_valid  (valid),
        .slot_live   (live)
    );

    assign sel_if    = sel[ST_IF];
    assign sel_rf    = sel[ST_RF];
    assign sel_alu   = sel[ST_ALU];
    assign sel_mem   = sel[ST_MEM];

    assign rf_word   = word[0];
    assign rf_valid  = valid[0];
    assign alu_word  = word[1];
    assign alu_valid = valid[1];
    assign mem_word  = word[2];
    assign mem_valid = valid[2];
    assign wb_word   = word[3];
    assign wb_valid  = valid[3];

endmodule

// File: rtl/exc_annul_ctrl_checker.sv
module exc_annul_ctrl_checker #(
    parameter int            W            = 32,
    parameter int            AW           = 32,
    parameter logic [W-1:0]  NOP_WORD     = 32'hA000_0000,
    parameter logic [W-1:0]  CAPTURE_WORD = 32'hB000_0001
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fetch_valid,
    input logic [1:0]    sel_if,
    input logic [1:0]    sel_rf,
    input logic [1:0]    sel_alu,
    input logic [1:0]    sel_mem,
    input logic          redirect,
    input logic [AW-1:0] handler_pc,
    input logic [W-1:0]  rf_word,
    input logic          rf_valid,
    input logic [W-1:0]  alu_word,
    input logic          alu_valid,
    input logic [W-1:0]  mem_word,
    input logic          mem_valid,
    input logic [W-1:0]  wb_word,
    input logic          wb_valid
);

    // R1: reset empties every slot
    a_r1_reset_empties: assert property (@(posedge clk)
        !rst_n |=> (!rf_valid && !alu_valid && !mem_valid && !wb_valid));

    // R2: with no redirect every stage passes its instruction
    a_r2_quiet_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect |-> (sel_if == 2'b00 && sel_rf == 2'b00 &&
                       sel_alu == 2'b00 && sel_mem == 2'b00));

    // R3: a redirect captures exactly one stage
    a_r3_single_capture: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> $onehot({sel_if == 2'b10, sel_rf == 2'b10,
                              sel_alu == 2'b10, sel_mem == 2'b10}));

    // R4: a capture select at the memory stage lands in write-back
    a_r4_capture_lands: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sel_mem) == 2'b10) |-> (wb_word == CAPTURE_WORD && wb_valid));

    // R4: an annul select at fetch lands as a NOP in decode
    a_r4_annul_lands: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sel_if) == 2'b01) |-> (rf_word == NOP_WORD));

    // R6: no redirect means a zero handler address
    a_r6_idle_vector: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect |-> (handler_pc == '0));

    // R7: an empty pipeline cannot redirect
    a_r7_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_valid && !rf_valid && !alu_valid && !mem_valid) |-> !redirect);

    // R8: a capture branch now in execute cannot be captured again
    a_r8_no_refault: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sel_rf) == 2'b10) |-> (sel_alu != 2'b10));

endmodule

bind exc_annul_ctrl exc_annul_ctrl_checker #(
    .W            (W),
    .AW           (AW),
    .NOP_WORD     (NOP_WORD),
    .CAPTURE_WORD (CAPTURE_WORD)
) u_chk (.*);

// File: tb/exc_annul_ctrl_test.sv
`timescale 1ns/1ps
module exc_annul_ctrl_test;

    localparam logic [31:0] NOPW  = 32'hA000_0000;
    localparam logic [31:0] CAPW  = 32'hB000_0001;
    localparam logic [31:0] V_IF  = 32'h0000_0100;
    localparam logic [31:0] V_RF  = 32'h0000_0200;
    localparam logic [31:0] V_ALU = 32'h0000_0300;
    localparam logic [31:0] V_MEM = 32'h0000_0400;
    localparam logic [31:0] V_IRQ = 32'h0000_0500;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] fetch_word = '0;
    logic fetch_valid = 1'b0, f_if = 1'b0, f_rf = 1'b0, f_alu = 1'b0, f_mem = 1'b0, irq = 1'b0;
    logic [1:0] sel_if, sel_rf, sel_alu, sel_mem;
    logic redirect;
    logic [31:0] handler_pc, rf_word, alu_word, mem_word, wb_word;
    logic rf_valid, alu_valid, mem_valid, wb_valid;

    int checks = 0, errors = 0;
    bit done = 0;

    // bench model: slot 0..3 = decode, execute, memory, write-back
    logic [31:0] m_word [4];
    logic        m_valid [4];
    int          m_tag [4];      // 0 live, 1 annulled, 2 capture
    logic [1:0]  e_sel [4];
    logic        e_redir;
    logic [31:0] e_vec;
    logic [31:0] p_word;
    logic        p_fv;

    always #4 clk = ~clk;

    exc_annul_ctrl uut (
        .clk(clk), .rst_n(rst_n), .fetch_word(fetch_word), .fetch_valid(fetch_valid),
        .fault_ifetch(f_if), .fault_illegal(f_rf), .fault_divzero(f_alu), .fault_daddr(f_mem),
        .irq_req(irq), .sel_if(sel_if), .sel_rf(sel_rf), .sel_alu(sel_alu), .sel_mem(sel_mem),
        .redirect(redirect), .handler_pc(handler_pc),
        .rf_word(rf_word), .rf_valid(rf_valid), .alu_word(alu_word), .alu_valid(alu_valid),
        .mem_word(mem_word), .mem_valid(mem_valid), .wb_word(wb_word), .wb_valid(wb_valid)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic model_eval();
        bit live [4];
        bit hit [4];
        int win = -1;
        live[0] = fetch_valid;
        for (int k = 1; k < 4; k++) live[k] = m_valid[k-1] && (m_tag[k-1] == 0);
        hit[0] = live[0] && (f_if || irq);
        hit[1] = live[1] && f_rf;
        hit[2] = live[2] && f_alu;
        hit[3] = live[3] && f_mem;
        for (int i = 0; i < 4; i++) if (hit[i]) win = i;
        e_redir = (win >= 0);
        for (int i = 0; i < 4; i++) e_sel[i] = (i == win) ? 2'b10 : ((win > i) ? 2'b01 : 2'b00);
        case (win)
            0: e_vec = f_if ? V_IF : V_IRQ;
            1: e_vec = V_RF;
            2: e_vec = V_ALU;
            3: e_vec = V_MEM;
            default: e_vec = '0;
        endcase
    endtask

    task automatic model_advance();
        for (int k = 3; k >= 0; k--) begin
            logic [31:0] w;
            int t;
            m_valid[k] = (k == 0) ? p_fv : m_valid[k-1];
            w = (k == 0) ? p_word : m_word[k-1];
            t = (k == 0) ? 0 : m_tag[k-1];
            if (e_sel[k] == 2'b01) begin w = NOPW; t = 1; end
            else if (e_sel[k] == 2'b10) begin w = CAPW; t = 2; end
            m_word[k] = w;
            m_tag[k] = t;
        end
    endtask

    // One cycle: advance model over the last edge, drive, compare every output.
    task automatic cyc(input logic fv, input logic [31:0] w, input logic fi, input logic fr,
                       input logic fa, input logic fm, input logic ir);
        @(negedge clk);
        model_advance();
        fetch_valid = fv; fetch_word = w; f_if = fi; f_rf = fr; f_alu = fa; f_mem = fm; irq = ir;
        p_word = w; p_fv = fv;
        #1;
        model_eval();
        chk(rf_valid == m_valid[0] && rf_word == m_word[0], "R2/R4 decode slot", rf_word, m_word[0]);
        chk(alu_valid == m_valid[1] && alu_word == m_word[1], "R2/R4 execute slot", alu_word, m_word[1]);
        chk(mem_valid == m_valid[2] && mem_word == m_word[2], "R2/R4 memory slot", mem_word, m_word[2]);
        chk(wb_valid == m_valid[3] && wb_word == m_word[3], "R2/R4 write-back slot", wb_word, m_word[3]);
        chk({sel_mem, sel_alu, sel_rf, sel_if} == {e_sel[3], e_sel[2], e_sel[1], e_sel[0]},
            "R3/R5 selects", {24'd0, sel_mem, sel_alu, sel_rf, sel_if},
            {24'd0, e_sel[3], e_sel[2], e_sel[1], e_sel[0]});
        chk(redirect == e_redir, "R3 redirect", {31'd0, redirect}, {31'd0, e_redir});
        chk(handler_pc == e_vec, "R6 handler_pc", handler_pc, e_vec);
    endtask

    task automatic fill(input int n, input logic [31:0] base);
        for (int i = 0; i < n; i++) cyc(1'b1, base + i, 0, 0, 0, 0, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int k = 0; k < 4; k++) begin
            m_word[k] = '0; m_valid[k] = 0; m_tag[k] = 0; e_sel[k] = 2'b00;
        end
        p_word = '0; p_fv = 0;
        // R1: reset state
        repeat (3) begin
            @(negedge clk); #1;
            chk(!rf_valid && !alu_valid && !mem_valid && !wb_valid, "R1 valids in reset",
                {28'd0, rf_valid, alu_valid, mem_valid, wb_valid}, 32'd0);
            chk(sel_if == 0 && sel_rf == 0 && sel_alu == 0 && sel_mem == 0 && !redirect,
                "R1 selects in reset", {23'd0, redirect, sel_mem, sel_alu, sel_rf, sel_if}, 32'd0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R7: every fault flag raised while the pipe is empty and fetch idle
        cyc(1'b0, 32'h1234_5678, 1, 1, 1, 1, 1);
        chk(!redirect, "R7 empty pipe ignores faults", {31'd0, redirect}, 32'd0);

        // R2: words advance one stage per cycle
        fill(5, 32'h0000_1000);
        chk(wb_word == 32'h0000_1000 && rf_word == 32'h0000_1003, "R2 word timing", wb_word, 32'h0000_1000);

        // R10: decode fault, then an older memory fault one cycle later
        cyc(1'b1, 32'h0000_2000, 0, 1, 0, 0, 0);
        chk(sel_rf == 2'b10 && sel_if == 2'b01 && sel_alu == 2'b00 && handler_pc == V_RF,
            "R10 first capture at decode", {30'd0, sel_rf}, 32'd2);
        cyc(1'b1, 32'h0000_3000, 0, 0, 1, 1, 0);
        chk(sel_mem == 2'b10 && sel_alu == 2'b01 && sel_rf == 2'b01 && sel_if == 2'b01,
            "R10 older memory fault takes over", {24'd0, sel_mem, sel_alu, sel_rf, sel_if}, 32'h0000_0095);
        chk(handler_pc == V_MEM, "R10 vector", handler_pc, V_MEM);
        // R8: faults on annulled and capture slots are ignored
        cyc(1'b1, 32'h0000_3004, 0, 1, 1, 1, 0);
        chk(!redirect, "R8 faults on rewritten slots", {31'd0, redirect}, 32'd0);
        chk(wb_word == CAPW && mem_word == NOPW && alu_word == NOPW && rf_word == NOPW,
            "R4 rewritten words", wb_word, CAPW);

        // R5: every stage faults in the same cycle
        fill(4, 32'h0000_4000);
        cyc(1'b1, 32'h0000_5000, 1, 1, 1, 1, 1);
        chk(sel_mem == 2'b10 && sel_alu == 2'b01 && sel_rf == 2'b01 && sel_if == 2'b01 && handler_pc == V_MEM,
            "R5 memory stage wins", handler_pc, V_MEM);

        // R6: execute-stage vector
        fill(4, 32'h0000_6000);
        cyc(1'b1, 32'h0000_7000, 0, 0, 1, 0, 0);
        chk(sel_alu == 2'b10 && sel_mem == 2'b00 && handler_pc == V_ALU, "R6 execute vector", handler_pc, V_ALU);

        // R9: interrupt handling
        fill(4, 32'h0000_8000);
        cyc(1'b1, 32'h0000_9000, 0, 0, 0, 0, 1);
        chk(sel_if == 2'b10 && handler_pc == V_IRQ, "R9 interrupt vector", handler_pc, V_IRQ);
        cyc(1'b1, 32'h0000_9004, 1, 0, 0, 0, 1);
        chk(sel_if == 2'b10 && handler_pc == V_IF, "R9 fetch fault beats interrupt", handler_pc, V_IF);
        cyc(1'b0, 32'h0000_9008, 0, 0, 0, 0, 1);
        chk(!redirect, "R9 interrupt on idle fetch ignored", {31'd0, redirect}, 32'd0);

        // random traffic, checked against the model every cycle
        for (int n = 0; n < 3000; n++) begin
            cyc(($urandom % 8) != 0, $urandom,
                ($urandom % 16) == 0, ($urandom % 12) == 0,
                ($urandom % 12) == 0, ($urandom % 14) == 0, ($urandom % 24) == 0);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule